// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the memory address for a two-operand, register-memory instruction set with 32-bit addresses. It holds a small register file with one write port. Each request names a base register, an index register, a two-bit scale, a displacement with a size code and one of four address forms. One clock later the block presents the effective address together with a valid flag.

The block also looks at the operand kinds of the instruction. The first operand is both read and written. Pairs that the instruction set does not allow raise an error flag in place of a valid address. Legal pairs that do not touch memory raise neither flag. The address output keeps its last valid value until the next valid result.

Top module: `ea_gen_top`

## Requirements
- R1: With `req_mode`=0 (register indirect) the address equals the base register value, whatever the index, scale and displacement inputs hold.
- R2: With `req_mode`=1 the address is base plus the extended displacement.
- R3: With `req_mode`=2 the address is base plus the index value shifted left by `scale` (0..3, a factor of 1, 2, 4 or 8).
- R4: With `req_mode`=3 the address is base plus the shifted index plus the extended displacement.
- R5: The `disp_size` code works as follows:
  - 0 sign-extends `disp[7:0]`.
  - 1 sign-extends `disp[15:0]`.
  - 2 and 3 take all 32 bits.
  - Any bits above the selected size have no effect.
- R6: All sums wrap modulo 2^32.
- R7: The operand kind codes are 0 register, 1 immediate, 2 memory and 3 reserved, given as `dst_kind` for the first operand and `src_kind` for the second. The legal pairs are reg/reg, reg/imm, reg/mem, mem/reg and mem/imm. Any other pair on a request sets `ea_error` and clears `ea_valid` in the next cycle, and the address holds.
- R8: A legal pair with no memory operand (reg/reg, reg/imm) gives neither `ea_valid` nor `ea_error`, and the address holds.
- R9: Results appear one clock after the request. Without a request, both `ea_valid` and `ea_error` are low in the next cycle and `ea_addr` holds its value.
- R10: A synchronous active-low `rst_n` clears `ea_valid`, `ea_error`, `ea_addr` and every register file entry to zero.
- R11: When a register write and a base or index read name the same register in the same cycle, the read sees the value being written.
- R12: A written register value is used by every later request that names that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register file write enable |
| wr_sel | input | 3 | Register written |
| wr_data | input | 32 | Value written |
| req_valid | input | 1 | Address request present |
| req_mode | input | 2 | Address form: 0 indirect, 1 base+disp, 2 base+scaled index, 3 base+scaled index+disp |
| base_sel | input | 3 | Base register number |
| index_sel | input | 3 | Index register number |
| scale | input | 2 | Index shift amount |
| disp | input | 32 | Displacement field |
| disp_size | input | 2 | Displacement size code: 0 8-bit, 1 16-bit, 2/3 32-bit |
| dst_kind | input | 2 | Kind of first operand |
| src_kind | input | 2 | Kind of second operand |
| ea_valid | output | 1 | Address valid, one cycle after a legal memory request |
| ea_error | output | 1 | Illegal operand pair seen one cycle earlier |
| ea_addr | output | 32 | Effective address, held between valid results |

## Verification
Every address form is driven with the same base and index values, so a wrong form selection shows up as a distinct wrong value. All four scales are swept to separate the shift amounts. Displacements carry a set sign bit and junk in their upper bits, which separates sign extension from zero extension and from no truncation. Sums that cross 2^32 expose missing wrap-around. All sixteen kinds of operand pair are not needed: legal, illegal and non-memory pairs are mixed so that the held address distinguishes "no update" from "update". A write and a read of the same register in one cycle tell forwarding apart from reading the stale value.

// File: rtl/ea_pkg.sv
// Shared encodings for the effective address generator.
// Assumes 2-bit codes for address form, displacement size and operand kind.
package ea_pkg;
    typedef enum logic [1:0] {
        MODE_IND       = 2'd0,
        MODE_DISP      = 2'd1,
        MODE_SIDX      = 2'd2,
        MODE_SIDX_DISP = 2'd3
    } ea_mode_e;

    typedef enum logic [1:0] {
        DSZ_8   = 2'd0,
        DSZ_16  = 2'd1,
        DSZ_32  = 2'd2,
        DSZ_32B = 2'd3
    } dsz_e;

    typedef enum logic [1:0] {
        OPK_REG = 2'd0,
        OPK_IMM = 2'd1,
        OPK_MEM = 2'd2,
        OPK_RSV = 2'd3
    } opk_e;

    typedef struct packed {
        logic legal;
        logic has_mem;
    } pair_chk_t;
endpackage

// File: rtl/ea_regfile.sv
// Register file with one write port and RD_N combinational read ports.
// A read that names the register being written this cycle returns the new
// value. Assumes REG_N is a power of two.
module ea_regfile #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 8,
    parameter int RD_N   = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [$clog2(REG_N)-1:0]              wr_sel,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic [RD_N-1:0][$clog2(REG_N)-1:0]    rd_sel,
    output logic [RD_N-1:0][DATA_W-1:0]           rd_data
);
    logic [DATA_W-1:0] regs [REG_N];

    // Storage update: clear on reset, otherwise take the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_sel] <= wr_data;
        end
    end

    // Read ports, each forwarding a same-cycle write.
    for (genvar g = 0; g < RD_N; g++) begin : g_rd
        assign rd_data[g] = (wr_en && (wr_sel == rd_sel[g])) ? wr_data : regs[rd_sel[g]];
    end
endmodule

// File: rtl/ea_disp_ext.sv
// Widens the displacement field according to its size code.
// Assumes DATA_W >= 16; the 32-bit codes pass the field unchanged.
module ea_disp_ext #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] disp_raw,
    input  ea_pkg::dsz_e      size,
    output logic [DATA_W-1:0] disp_wide
);
    // Size selection with sign extension of the short forms.
    always_comb begin
        case (size)
            ea_pkg::DSZ_8:  disp_wide = {{(DATA_W-8){disp_raw[7]}}, disp_raw[7:0]};
            ea_pkg::DSZ_16: disp_wide = {{(DATA_W-16){disp_raw[15]}}, disp_raw[15:0]};
            default:        disp_wide = disp_raw;
        endcase
    end
endmodule

// File: rtl/ea_scaler.sv
// Scales the index by a power of two given as a shift amount.
// Assumes bits shifted out are discarded (modular arithmetic).
module ea_scaler #(
    parameter int DATA_W  = 32,
    parameter int SCALE_W = 2
) (
    input  logic [DATA_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] shamt,
    output logic [DATA_W-1:0]  scaled
);
    // Left shift by the scale field.
    always_comb scaled = index_val << shamt;
endmodule

// File: rtl/ea_pair_check.sv
// Classifies the operand kind pair of an instruction.
// legal: the pair is allowed; has_mem: a memory operand is involved.
module ea_pair_check (
    input  ea_pkg::opk_e      dst,
    input  ea_pkg::opk_e      src,
    output ea_pkg::pair_chk_t res
);
    // Pair table: a register first operand takes any non-reserved second
    // operand; a memory first operand takes a register or immediate.
    always_comb begin
        res = '0;
        case (dst)
            ea_pkg::OPK_REG: begin
                res.legal   = (src != ea_pkg::OPK_RSV);
                res.has_mem = (src == ea_pkg::OPK_MEM);
            end
            ea_pkg::OPK_MEM: begin
                res.legal   = (src == ea_pkg::OPK_REG) || (src == ea_pkg::OPK_IMM);
                res.has_mem = 1'b1;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/ea_gen_top.sv
// Effective address generator: reads base and index from the register file,
// scales the index, widens the displacement, sums per address form and
// registers address, valid and error. Assumes one request per cycle and no
// backpressure.
module ea_gen_top #(
    parameter int DATA_W  = 32,
    parameter int REG_N   = 8,
    parameter int SCALE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(REG_N)-1:0] wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     req_valid,
    input  logic [1:0]               req_mode,
    input  logic [$clog2(REG_N)-1:0] base_sel,
    input  logic [$clog2(REG_N)-1:0] index_sel,
    input  logic [SCALE_W-1:0]       scale,
    input  logic [DATA_W-1:0]        disp,
    input  logic [1:0]               disp_size,
    input  logic [1:0]               dst_kind,
    input  logic [1:0]               src_kind,
    output logic                     ea_valid,
    output logic                     ea_error,
    output logic [DATA_W-1:0]        ea_addr
);
    localparam int RD_N = 2;

    logic [RD_N-1:0][$clog2(REG_N)-1:0] rd_sel;
    logic [RD_N-1:0][DATA_W-1:0]        rd_data;
    logic [DATA_W-1:0]                  disp_wide;
    logic [DATA_W-1:0]                  idx_scaled;
    logic [DATA_W-1:0]                  sum;
    ea_pkg::pair_chk_t                  pair;
    logic                               take_addr;

    assign rd_sel[0] = base_sel;
    assign rd_sel[1] = index_sel;

    ea_regfile #(.DATA_W(DATA_W), .REG_N(REG_N), .RD_N(RD_N)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    ea_disp_ext #(.DATA_W(DATA_W)) u_dx (
        .disp_raw  (disp),
        .size      (ea_pkg::dsz_e'(disp_size)),
        .disp_wide (disp_wide)
    );

    ea_scaler #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_sc (
        .index_val (rd_data[1]),
        .shamt     (scale),
        .scaled    (idx_scaled)
    );

    ea_pair_check u_pc (
        .dst (ea_pkg::opk_e'(dst_kind)),
        .src (ea_pkg::opk_e'(src_kind)),
        .res (pair)
    );

    // Address sum chosen by the address form.
    always_comb begin
        case (ea_pkg::ea_mode_e'(req_mode))
            ea_pkg::MODE_IND:  sum = rd_data[0];
            ea_pkg::MODE_DISP: sum = rd_data[0] + disp_wide;
            ea_pkg::MODE_SIDX: sum = rd_data[0] + idx_scaled;
            default:           sum = rd_data[0] + idx_scaled + disp_wide;
        endcase
    end

    assign take_addr = req_valid && pair.legal && pair.has_mem;

    // Output stage: flags every cycle, address only on a valid result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_valid <= 1'b0;
            ea_error <= 1'b0;
            ea_addr  <= '0;
        end else begin
            ea_valid <= take_addr;
            ea_error <= req_valid && !pair.legal;
            if (take_addr) ea_addr <= sum;
        end
    end
endmodule

// File: rtl/ea_gen_chk.sv
// Property checker for ea_gen_top, attached by bind. Observes the request
// side flags and the registered outputs only.
module ea_gen_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        dst_kind,
    input logic [1:0]        src_kind,
    input logic              ea_valid,
    input logic              ea_error,
    input logic [DATA_W-1:0] ea_addr
);
    logic pair_ok;
    logic pair_mem;

    assign pair_ok  = ((dst_kind == 2'd0) && (src_kind != 2'd3)) ||
                      ((dst_kind == 2'd2) && ((src_kind == 2'd0) || (src_kind == 2'd1)));
    assign pair_mem = (dst_kind == 2'd2) || (src_kind == 2'd2);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && ea_error));

    assert_illegal_raises_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pair_ok) |=> (ea_error && !ea_valid));

    assert_nonmem_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair_ok && !pair_mem) |=> (!ea_error && !ea_valid));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!ea_valid && !ea_error));

    assert_addr_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && pair_ok && pair_mem) |=> $stable(ea_addr));

    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (!ea_valid && !ea_error && (ea_addr == '0)));
endmodule

bind ea_gen_top ea_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .dst_kind  (dst_kind),
    .src_kind  (src_kind),
    .ea_valid  (ea_valid),
    .ea_error  (ea_error),
    .ea_addr   (ea_addr)
);

// File: tb/test_ea_gen_top.sv
// Bench for ea_gen_top: a behavioural reference model predicts the outputs
// for every clock, and the bench compares them half a cycle after each edge.
module test_ea_gen_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [2:0]  base_sel = '0;
    logic [2:0]  index_sel = '0;
    logic [1:0]  scale = '0;
    logic [31:0] disp = '0;
    logic [1:0]  disp_size = '0;
    logic [1:0]  dst_kind = '0;
    logic [1:0]  src_kind = '0;
    logic        ea_valid;
    logic        ea_error;
    logic [31:0] ea_addr;

    int unsigned ref_regs [8];
    logic        exp_valid = 1'b0;
    logic        exp_error = 1'b0;
    logic [31:0] exp_addr = '0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    ea_gen_top i_ea_gen_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_mode(req_mode), .base_sel(base_sel),
        .index_sel(index_sel), .scale(scale), .disp(disp), .disp_size(disp_size),
        .dst_kind(dst_kind), .src_kind(src_kind),
        .ea_valid(ea_valid), .ea_error(ea_error), .ea_addr(ea_addr)
    );

    always #5 clk = ~clk;

    function automatic bit pair_allowed(input logic [1:0] d, input logic [1:0] s);
        return (d == 0 && s == 0) || (d == 0 && s == 1) || (d == 0 && s == 2) ||
               (d == 2 && s == 0) || (d == 2 && s == 1);
    endfunction

    function automatic int unsigned read_reg(input logic [2:0] sel);
        if (wr_en && wr_sel == sel) return wr_data;
        return ref_regs[sel];
    endfunction

    // Predict next-cycle outputs from the driven inputs, then advance.
    task automatic step(input string tag);
        longint acc;
        int     dv;
        if (!rst_n) begin
            exp_valid = 0; exp_error = 0; exp_addr = 0;
            foreach (ref_regs[k]) ref_regs[k] = 0;
        end else begin
            exp_valid = 0; exp_error = 0;
            if (req_valid && !pair_allowed(dst_kind, src_kind)) exp_error = 1;
            else if (req_valid && (dst_kind == 2 || src_kind == 2)) begin
                case (disp_size)
                    2'd0: dv = int'(byte'(disp[7:0]));
                    2'd1: dv = int'(shortint'(disp[15:0]));
                    default: dv = int'(disp);
                endcase
                acc = longint'(read_reg(base_sel));
                if (req_mode == 1 || req_mode == 3) acc = acc + longint'(dv);
                if (req_mode >= 2) acc = acc + longint'(read_reg(index_sel)) * (longint'(1) << scale);
                exp_valid = 1;
                exp_addr = acc[31:0];
            end
            if (wr_en) ref_regs[wr_sel] = wr_data;
        end
        @(negedge clk);
        n_checks++;
        if (ea_valid !== exp_valid || ea_error !== exp_error || ea_addr !== exp_addr) begin
            n_fail++;
            $display("FAIL %s: got valid=%b error=%b addr=%h, expected valid=%b error=%b addr=%h",
                     tag, ea_valid, ea_error, ea_addr, exp_valid, exp_error, exp_addr);
        end
    endtask

    task automatic idle();
        wr_en = 0; req_valid = 0;
    endtask

    task automatic do_write(input logic [2:0] s, input logic [31:0] v, input string tag);
        idle(); wr_en = 1; wr_sel = s; wr_data = v;
        step(tag);
    endtask

    task automatic do_req(input logic [1:0] m, input logic [2:0] b, input logic [2:0] i,
                          input logic [1:0] sc, input logic [31:0] d, input logic [1:0] dz,
                          input logic [1:0] dk, input logic [1:0] sk, input string tag);
        idle(); req_valid = 1; req_mode = m; base_sel = b; index_sel = i;
        scale = sc; disp = d; disp_size = dz; dst_kind = dk; src_kind = sk;
        step(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        step("R10 reset outputs");
        rst_n = 1;
        do_write(1, 32'h0000_1000, "R12 write r1, R9 no request");
        do_write(2, 32'h0000_0010, "R12 write r2");
        do_write(3, 32'hFFFF_FFF0, "R12 write r3");
        do_write(6, 32'h8000_0000, "R12 write r6");
        do_req(0, 5, 1, 3, 32'h55, 2, 2, 0, "R10 unwritten register reads zero");
        do_req(0, 1, 2, 3, 32'h0000_0055, 2, 0, 2, "R1 indirect ignores index/scale/disp");
        do_req(1, 1, 2, 1, 32'h1234_5680, 0, 2, 1, "R5 8-bit negative displacement");
        do_req(1, 1, 2, 1, 32'hABCD_8001, 1, 2, 0, "R5 16-bit negative displacement");
        do_req(1, 1, 2, 1, 32'h0000_0100, 2, 0, 2, "R2 base plus displacement");
        do_req(1, 1, 2, 1, 32'h1234_5678, 3, 2, 1, "R5 code 3 is 32-bit");
        for (int s = 0; s < 4; s++)
            do_req(2, 1, 2, s[1:0], 32'hFFFF_FFFF, 2, 2, 0, "R3 scaled index");
        do_req(3, 1, 2, 2, 32'h0000_00F0, 0, 0, 2, "R4 scaled index plus displacement");
        do_req(1, 3, 0, 0, 32'h0000_0020, 2, 2, 0, "R6 wrap on displacement");
        do_req(3, 6, 6, 1, 32'h0000_007F, 0, 2, 1, "R6 wrap on scaled index");
        do_req(1, 1, 2, 0, 32'h4, 2, 2, 2, "R7 mem/mem rejected");
        do_req(1, 1, 2, 0, 32'h8, 2, 1, 1, "R7 imm/imm rejected");
        do_req(1, 1, 2, 0, 32'hC, 2, 1, 0, "R7 imm/reg rejected");
        do_req(1, 1, 2, 0, 32'hC, 2, 0, 3, "R7 reserved kind rejected");
        do_req(1, 1, 2, 0, 32'h10, 2, 0, 0, "R8 reg/reg no flags");
        do_req(1, 1, 2, 0, 32'h14, 2, 0, 1, "R8 reg/imm no flags");
        do_req(0, 2, 0, 0, 32'h0, 2, 2, 1, "R7 mem/imm accepted");
        idle(); step("R9 idle holds address");
        idle(); wr_en = 1; wr_sel = 4; wr_data = 32'h0000_2000;
        req_valid = 1; req_mode = 2; base_sel = 4; index_sel = 4; scale = 0;
        disp = 0; disp_size = 2; dst_kind = 0; src_kind = 2;
        step("R11 same-cycle write forwarded");
        do_req(0, 4, 0, 0, 32'h0, 2, 2, 0, "R12 written value used later");
        idle(); req_valid = 1; rst_n = 0;
        step("R10 reset during request");
        rst_n = 1;
        do_req(0, 1, 0, 0, 32'h0, 2, 2, 0, "R10 register file cleared");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule